// File: doc/BRIEF.md
# Tic-Tac-Toe Move Engine

This block keeps the state of a 3x3 noughts-and-crosses board and applies one move per request. A move is given as a symbol (X or O), a row and a column, and is started by a rising edge on a request strobe. A small three-state controller first checks the move against the board. If the square is free and in range and no player has won yet, the move is written. A rejected move leaves the board untouched and is flagged as a repeat. Each processed move ends with a one-cycle done pulse.

Win detection is evaluated continuously from the stored board over every row, column and both diagonals. The result is exposed as per-player win flags, a board-full flag and a nine-bit mask of the squares on winning lines, so that a display can highlight them. The packed board is also exposed so that a renderer can draw it. A synchronous new-game input clears the board, the flags and any move still in progress.

Top module: `ttt_engine`

## Requirements
- R1: After the asynchronous active-low reset, done_o, is_repeat_o, is_full_o, x_win_o and o_win_o are low, win_mask_o is zero and every square of board_o is empty.
- R2: A move is started only by a rising edge of req_i sampled in the idle state. For an accepted move, done_o is high for exactly one cycle, starting three clock edges after the req_i rising edge is driven (the sampling edge plus two more). For a rejected move, it starts two edges after.
- R3: Square (row, col) occupies board_o bits [2*(row*3+col)+1 : 2*(row*3+col)] with 00 = empty, 01 = X, 10 = O. An accepted move writes 01 when choice_i is 0 and 10 when choice_i is 1. A written square never changes until a new game is started.
- R4: A move to an occupied square is rejected: is_repeat_o is high together with done_o and board_o is unchanged.
- R5: x_win_o (o_win_o) is high while any of the eight lines (three rows, three columns, two diagonals) holds three X (O) squares.
- R6: Bit row*3+col of win_mask_o is high exactly when that square lies on a line that holds three equal non-empty symbols, and win_mask_o is zero when no line does.
- R7: is_full_o is high exactly when all nine squares are non-empty.
- R8: Once x_win_o or o_win_o is high, every further move is rejected with is_repeat_o until a new game is started.
- R9: A high new_game_i at a clock edge empties the board, lowers all flags, drops any move in progress and returns the controller to idle.
- R10: A row or column value of 3 is rejected as a repeat. A req_i held high, or a rising edge during a move in progress, starts no further move.
- R11: is_repeat_o is never high without done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| new_game_i | input | 1 | Synchronous clear of board, flags and pending move |
| req_i | input | 1 | Move request; a rising edge starts a move |
| choice_i | input | 1 | Symbol: 0 = X, 1 = O |
| row_i | input | 2 | Board row 0..2 |
| col_i | input | 2 | Board column 0..2 |
| done_o | output | 1 | One-cycle pulse when a move has been processed |
| is_repeat_o | output | 1 | Move rejected; valid with done_o |
| is_full_o | output | 1 | All nine squares occupied |
| x_win_o | output | 1 | X holds a full line |
| o_win_o | output | 1 | O holds a full line |
| win_mask_o | output | 9 | Squares on winning lines, bit row*3+col |
| board_o | output | 18 | Packed board, two bits per square |

## Verification
A wrong stored square shows at board_o on the cycle after the faulty write. A wrong square also feeds straight into the line evaluator, so a corrupted cell flips x_win_o, o_win_o, is_full_o or win_mask_o in that same cycle. A controller stuck in the wrong state shows as a missing, late or doubled done_o pulse on the next request, or as a repeat flag on a legal move. The bench compares every flag and the whole board after each move and checks the done timing to the exact edge, so a fault surfaces within one move.

// File: rtl/ttt_pkg.sv
package ttt_pkg;
  typedef enum logic [1:0] {
    CELL_EMPTY = 2'b00,
    CELL_X     = 2'b01,
    CELL_O     = 2'b10
  } cell_e;

  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_CHECK = 2'd1,
    ST_FILL  = 2'd2
  } state_e;
endpackage

// File: rtl/ttt_board.sv
module ttt_board #(
  parameter int N = 3,
  localparam int CELLS = N * N,
  localparam int IW = $clog2(CELLS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 we_i,
  input  logic [IW-1:0]        idx_i,
  input  ttt_pkg::cell_e       sym_i,
  output logic [2*CELLS-1:0]   board_o
);
  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    logic [1:0] cell_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          cell_q <= ttt_pkg::CELL_EMPTY;
      else if (clr_i)                       cell_q <= ttt_pkg::CELL_EMPTY;
      else if (we_i && idx_i == IW'(i))     cell_q <= sym_i;
    end
    assign board_o[2*i +: 2] = cell_q;
  end
endmodule

// File: rtl/ttt_line_eval.sv
module ttt_line_eval #(
  parameter int N = 3,
  localparam int CELLS = N * N,
  localparam int LINES = 2 * N + 2
) (
  input  logic [2*CELLS-1:0] board_i,
  output logic               x_win_o,
  output logic               o_win_o,
  output logic               full_o,
  output logic [CELLS-1:0]   win_mask_o
);
  logic [LINES-1:0] line_x, line_o;
  logic [CELLS-1:0] line_mask [LINES];
  logic [CELLS-1:0] occ;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [N-1:0] is_x, is_o;
    logic [CELLS-1:0] m;
    for (genvar k = 0; k < N; k++) begin : g_pos
      // rows, then columns, then main and anti diagonal
      localparam int IDX = (l < N)     ? l * N + k :
                           (l < 2 * N) ? k * N + (l - N) :
                           (l == 2 * N)? k * N + k :
                                         k * N + (N - 1 - k);
      assign is_x[k] = board_i[2*IDX +: 2] == ttt_pkg::CELL_X;
      assign is_o[k] = board_i[2*IDX +: 2] == ttt_pkg::CELL_O;
      assign m[IDX]  = 1'b1;
    end
    for (genvar c = 0; c < CELLS; c++) begin : g_fill
      // cells not on this line
      localparam bit ON = (l < N)     ? (c / N == l) :
                          (l < 2 * N) ? (c % N == l - N) :
                          (l == 2 * N)? (c / N == c % N) :
                                        (c / N + c % N == N - 1);
      if (!ON) begin : g_off
        assign m[c] = 1'b0;
      end
    end
    assign line_x[l]    = &is_x;
    assign line_o[l]    = &is_o;
    assign line_mask[l] = m;
  end

  for (genvar c = 0; c < CELLS; c++) begin : g_occ
    assign occ[c] = board_i[2*c +: 2] != ttt_pkg::CELL_EMPTY;
  end

  always_comb begin
    win_mask_o = '0;
    for (int l = 0; l < LINES; l++) begin
      if (line_x[l] || line_o[l]) win_mask_o |= line_mask[l];
    end
  end

  assign x_win_o = |line_x;
  assign o_win_o = |line_o;
  assign full_o  = &occ;
endmodule

// File: rtl/ttt_ctrl.sv
module ttt_ctrl #(
  parameter int N = 3,
  localparam int CELLS = N * N,
  localparam int IW = $clog2(CELLS),
  localparam int RW = $clog2(N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               new_game_i,
  input  logic               req_i,
  input  logic               choice_i,
  input  logic [RW-1:0]      row_i,
  input  logic [RW-1:0]      col_i,
  input  logic [2*CELLS-1:0] board_i,
  input  logic               game_over_i,
  output logic               done_o,
  output logic               repeat_o,
  output logic               we_o,
  output logic [IW-1:0]      idx_o,
  output ttt_pkg::cell_e     sym_o
);
  import ttt_pkg::*;

  state_e      state_q, state_d;
  logic        req_q;
  logic        sym_q;
  logic [RW-1:0] row_q, col_q;
  logic        done_q, rep_q;
  logic        in_range, occupied, reject;
  logic [31:0] idx_full;

  assign idx_full = 32'(row_q) * 32'(N) + 32'(col_q);
  assign idx_o    = idx_full[IW-1:0];
  assign in_range = (32'(row_q) < 32'(N)) && (32'(col_q) < 32'(N));
  assign occupied = in_range && (board_i[2*idx_o +: 2] != CELL_EMPTY);
  assign reject   = !in_range || occupied || game_over_i;
  assign sym_o    = sym_q ? CELL_O : CELL_X;
  assign we_o     = (state_q == ST_FILL) && !new_game_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_START: if (req_i && !req_q) state_d = ST_CHECK;
      ST_CHECK: state_d = reject ? ST_START : ST_FILL;
      ST_FILL:  state_d = ST_START;
      default:  state_d = ST_START;
    endcase
    if (new_game_i) state_d = ST_START;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_START;
      req_q   <= 1'b0;
      sym_q   <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      done_q  <= 1'b0;
      rep_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_i;
      done_q  <= 1'b0;
      rep_q   <= 1'b0;
      if (state_q == ST_START && req_i && !req_q) begin
        sym_q <= choice_i;
        row_q <= row_i;
        col_q <= col_i;
      end
      if (!new_game_i) begin
        if (state_q == ST_CHECK && reject) begin
          done_q <= 1'b1;
          rep_q  <= 1'b1;
        end
        if (state_q == ST_FILL) done_q <= 1'b1;
      end
    end
  end

  assign done_o   = done_q;
  assign repeat_o = rep_q;
endmodule

// File: rtl/ttt_engine.sv
module ttt_engine #(
  parameter int N = 3,
  localparam int CELLS = N * N,
  localparam int IW = $clog2(CELLS),
  localparam int RW = $clog2(N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               new_game_i,
  input  logic               req_i,
  input  logic               choice_i,
  input  logic [RW-1:0]      row_i,
  input  logic [RW-1:0]      col_i,
  output logic               done_o,
  output logic               is_repeat_o,
  output logic               is_full_o,
  output logic               x_win_o,
  output logic               o_win_o,
  output logic [CELLS-1:0]   win_mask_o,
  output logic [2*CELLS-1:0] board_o
);
  logic           we;
  logic [IW-1:0]  idx;
  ttt_pkg::cell_e sym;

  ttt_ctrl #(.N(N)) u_ctrl (
    .clk_i, .rst_ni, .new_game_i, .req_i, .choice_i, .row_i, .col_i,
    .board_i     (board_o),
    .game_over_i (x_win_o | o_win_o),
    .done_o,
    .repeat_o    (is_repeat_o),
    .we_o        (we),
    .idx_o       (idx),
    .sym_o       (sym)
  );

  ttt_board #(.N(N)) u_board (
    .clk_i, .rst_ni,
    .clr_i   (new_game_i),
    .we_i    (we),
    .idx_i   (idx),
    .sym_i   (sym),
    .board_o
  );

  ttt_line_eval #(.N(N)) u_eval (
    .board_i    (board_o),
    .x_win_o,
    .o_win_o,
    .full_o     (is_full_o),
    .win_mask_o
  );
endmodule

// File: rtl/ttt_engine_chk.sv
module ttt_engine_chk #(
  parameter int N = 3,
  localparam int CELLS = N * N,
  localparam int RW = $clog2(N)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               new_game_i,
  input logic               req_i,
  input logic               choice_i,
  input logic [RW-1:0]      row_i,
  input logic [RW-1:0]      col_i,
  input logic               done_o,
  input logic               is_repeat_o,
  input logic               is_full_o,
  input logic               x_win_o,
  input logic               o_win_o,
  input logic [CELLS-1:0]   win_mask_o,
  input logic [2*CELLS-1:0] board_o
);
  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_repeat_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_repeat_o |-> done_o);

  a_r4_repeat_keeps_board: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_repeat_o |-> $stable(board_o));

  a_r3_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !new_game_i |=> ((board_o & $past(board_o)) == $past(board_o)));

  a_r5_one_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(x_win_o && o_win_o));

  a_r6_mask_on_win: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_win_o || o_win_o) |-> ($countones(win_mask_o) >= N));

  a_r6_mask_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(x_win_o || o_win_o) |-> (win_mask_o == '0));

  a_r7_full_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_full_o && !new_game_i) |=> is_full_o);

  a_r8_frozen_after_win: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((x_win_o || o_win_o) && !new_game_i) |=> $stable(board_o));

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_game_i |=> (board_o == '0 && !x_win_o && !o_win_o && !is_full_o && !done_o));
endmodule

bind ttt_engine ttt_engine_chk #(.N(N)) u_chk (.*);

// File: tb/ttt_engine_tb.sv
module ttt_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic new_game = 1'b0, req = 1'b0, choice = 1'b0;
  logic [1:0] row = '0, col = '0;
  logic done, is_rep, is_full, x_win, o_win;
  logic [8:0]  mask;
  logic [17:0] board;

  int n_cmp = 0, n_err = 0, cyc = 0;
  logic [1:0] mb [9];

  always #4 clk = ~clk;

  ttt_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .new_game_i(new_game), .req_i(req),
    .choice_i(choice), .row_i(row), .col_i(col), .done_o(done),
    .is_repeat_o(is_rep), .is_full_o(is_full), .x_win_o(x_win), .o_win_o(o_win),
    .win_mask_o(mask), .board_o(board)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] pack_f();
    logic [17:0] b;
    for (int i = 0; i < 9; i++) b[2*i +: 2] = mb[i];
    return b;
  endfunction

  function automatic logic [8:0] wmask_f(input logic [1:0] s);
    logic [8:0] m = '0;
    for (int r = 0; r < 3; r++)
      if (mb[3*r] == s && mb[3*r+1] == s && mb[3*r+2] == s) m |= 9'b111 << (3*r);
    for (int c = 0; c < 3; c++)
      if (mb[c] == s && mb[c+3] == s && mb[c+6] == s) m |= 9'b001_001_001 << c;
    if (mb[0] == s && mb[4] == s && mb[8] == s) m |= 9'b100_010_001;
    if (mb[2] == s && mb[4] == s && mb[6] == s) m |= 9'b001_010_100;
    return m;
  endfunction

  function automatic bit full_f();
    for (int i = 0; i < 9; i++) if (mb[i] == 2'b00) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check_state(input string tag);
    logic [8:0] mx, mo;
    mx = wmask_f(2'b01);
    mo = wmask_f(2'b10);
    chk(board === pack_f(), {tag, " R3 board"}, board, pack_f());
    chk(x_win === |mx, {tag, " R5 x_win"}, x_win, |mx);
    chk(o_win === |mo, {tag, " R5 o_win"}, o_win, |mo);
    chk(mask === (mx | mo), {tag, " R6 mask"}, mask, mx | mo);
    chk(is_full === full_f(), {tag, " R7 full"}, is_full, full_f());
  endtask

  task automatic clear_model();
    for (int i = 0; i < 9; i++) mb[i] = 2'b00;
  endtask

  task automatic start_game();
    @(negedge clk) new_game = 1'b1;
    @(negedge clk) new_game = 1'b0;
    clear_model();
    chk(board === '0 && !x_win && !o_win && !is_full && !done, "R9 new game clears",
        {board, x_win, o_win, is_full, done}, 0);
  endtask

  task automatic move(input logic ch, input int r, input int c, input string tag);
    bit rej;
    int k;
    rej = (r > 2) || (c > 2) || (|wmask_f(2'b01)) || (|wmask_f(2'b10));
    if (!rej) rej = mb[r*3+c] != 2'b00;
    @(negedge clk);
    req = 1'b1; choice = ch; row = 2'(r); col = 2'(c);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!done && k < 10);
    chk(k == (rej ? 2 : 3), {tag, " R2 done timing"}, k, rej ? 2 : 3);
    chk(is_rep === rej, {tag, rej ? " R4/R8/R10 repeat" : " R4 accept"}, is_rep, rej);
    if (!rej) mb[r*3+c] = ch ? 2'b10 : 2'b01;
    check_state(tag);
    @(negedge clk) req = 1'b0;
    chk(done === 1'b0, {tag, " R2 single pulse"}, done, 0);
  endtask

  initial begin
    void'($urandom(32'd20091205));
    clear_model();
    repeat (3) @(negedge clk);
    chk(done === 0 && is_rep === 0 && mask === '0 && board === '0, "R1 reset outputs",
        {done, is_rep, mask, board}, 0);
    chk(!x_win && !o_win && !is_full, "R1 reset flags", {x_win, o_win, is_full}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after reset");

    // row win for X, then R8 rejection
    start_game();
    move(0, 1, 0, "dirA");
    move(1, 0, 0, "dirA");
    move(0, 1, 1, "dirA");
    move(1, 0, 0, "dirA R4 occupied");
    move(0, 1, 2, "dirA R5 row win");
    chk(mask === 9'b000_111_000, "R6 row1 mask", mask, 9'b000_111_000);
    move(1, 2, 2, "dirA R8 after win");

    // O anti-diagonal, out of range
    start_game();
    move(1, 0, 2, "dirB");
    move(1, 3, 0, "dirB R10 row3");
    move(0, 1, 3, "dirB R10 col3");
    move(1, 1, 1, "dirB");
    move(1, 2, 0, "dirB R5 diag");
    chk(o_win === 1'b1 && mask === 9'b001_010_100, "R6 anti-diag mask", mask, 9'b001_010_100);

    // fork: two lines at once
    start_game();
    move(0, 0, 1, "fork");
    move(0, 0, 2, "fork");
    move(0, 1, 0, "fork");
    move(0, 2, 0, "fork");
    move(0, 0, 0, "fork R6 two lines");
    chk(mask === 9'b001_001_111, "R6 fork mask", mask, 9'b001_001_111);

    // draw fills the board
    start_game();
    move(0, 0, 0, "draw"); move(1, 0, 1, "draw"); move(0, 0, 2, "draw");
    move(0, 1, 0, "draw"); move(1, 1, 1, "draw"); move(1, 1, 2, "draw");
    move(1, 2, 0, "draw"); move(0, 2, 1, "draw"); move(0, 2, 2, "draw R7 full");
    chk(is_full === 1'b1 && !x_win && !o_win, "R7 full no win", {is_full, x_win, o_win}, 3'b100);
    move(1, 1, 1, "draw R4 full repeat");

    // held request starts nothing more
    start_game();
    @(negedge clk);
    req = 1'b1; choice = 1'b0; row = 2'd2; col = 2'd2;
    repeat (3) @(negedge clk);
    chk(done === 1'b1, "R2 held req first done", done, 1);
    mb[8] = 2'b01;
    row = 2'd0; col = 2'd0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(done === 1'b0 && board === pack_f(), "R10 held req no move", {done, board}, pack_f());
    end
    req = 1'b0;

    // new game aborts a move in flight
    @(negedge clk);
    req = 1'b1; choice = 1'b1; row = 2'd1; col = 2'd1;
    @(negedge clk) new_game = 1'b1;
    @(negedge clk) new_game = 1'b0;
    clear_model();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(done === 1'b0 && board === '0, "R9 abort in flight", {done, board}, 0);
    end
    req = 1'b0;

    // random games
    for (int g = 0; g < 40; g++) begin
      start_game();
      for (int m = 0; m < 14; m++) begin
        move(1'($urandom % 2), int'($urandom % 4), int'($urandom % 4), "rand");
      end
    end

    summary();
    $finish;
  end
endmodule